// File: doc/BRIEF.md
# Zero-Turnaround Burst Synchronous SRAM

This block is a synthesizable behavioural model of a single-port synchronous SRAM whose command pipeline needs no idle cycle between a read and a write. On each rising clock edge it samples a control bundle and then moves the data one cycle later. The control bundle is a clock enable, three chip enables, read/write, advance/load, per-lane write enables, an address and a burst-order select. Read data flows straight out of the array during that data cycle. Write data is taken from the input bus at the edge that ends it.

A load command starts an access at an external address and fixes its direction. Advance commands then step a two-bit burst counter through either an interleaved or a linear order, and the burst keeps the direction it was loaded with. The data bus is split into input, output and output-enable ports. Output-enable is high only in the data cycle of a read. Holding the clock enable high freezes the whole block.

Top module: `zbt_sram`

## Requirements
- R1: When `cken_n` is high at an edge, that edge changes nothing. This holds for the burst counter, the pending data cycle, `doe`, `dout` and the memory.
- R2: The block is selected only when `ce1_n`=0, `ce2_n`=0 and `ce2`=1. A load with any one of these false neither reads nor writes.
- R3: A load-phase command (`adv`=0) while the block is not selected leaves `doe` low in the following cycle.
- R4: A selected load with `we_n`=1 presents the word at `addr` on `dout` in the next cycle with `doe`=1. A selected load with `we_n`=0 keeps `doe` low in the next cycle and stores `din` at the edge that ends that cycle.
- R5: With `adv`=1 the value of `we_n` is ignored. The burst continues in the direction latched at its load.
- R6: An advance (`adv`=1) after a deselect is a no-op. `doe` stays low and nothing is written.
- R7: Each bit of `bw_n` (active low) guards one 9-bit lane. Bit i covers `din`/`dout` bits [9i+8:9i], where bit 9i+8 is the lane's parity bit. Any mix of lanes may be written, and `bw_n`=4'b1111 writes nothing. The mask is sampled with each command and applied to the data of the following cycle.
- R8: With `seq_ilv`=1 at load, burst step k (k=0..3) uses the low two address bits XOR k. After the fourth step the order starts over.
- R9: With `seq_ilv`=0 at load, burst step k uses the low two address bits plus k, modulo 4. The upper bits are held and the order wraps after four steps.
- R10: After reset `doe` is low.
- R11: A read may be loaded in the data cycle of a write with no gap. The read returns the word just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cken_n | input | 1 | Clock enable, active low; high suspends the edge |
| ce1_n | input | 1 | Chip enable, active low |
| ce2_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| we_n | input | 1 | 1 = read, 0 = write (load cycles only) |
| adv | input | 1 | 1 = advance burst, 0 = load address or deselect |
| bw_n | input | 4 | Per-lane write enables, active low |
| addr | input | 6 | Word address |
| seq_ilv | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| din | input | 36 | Write data, four 9-bit lanes |
| dout | output | 36 | Read data, zero when not driving |
| doe | output | 1 | High during the data cycle of a read |

## Verification
A wrong burst counter or a wrong latched order shows at `dout` in the very next read data cycle, as a word from the neighbouring address. Corrupted direction or pending-cycle state shows as `doe` asserting in a write's data cycle, or as a word that changes when the burst should have been reading. That is visible one cycle after the faulty command. A lane-mask or suspend fault stays hidden in the array until the next read of the address. The bench therefore reads every written location back and compares whole words lane by lane.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cken_n,
  input  logic                ce1_n,
  input  logic                ce2_n,
  input  logic                ce2,
  input  logic                we_n,
  input  logic                adv,
  input  logic [LANES-1:0]    bw_n,
  input  logic [AW-1:0]       addr,
  input  logic                seq_ilv,
  input  logic [LANES*LW-1:0] din,
  output logic [LANES*LW-1:0] dout,
  output logic                doe
);
  localparam int DEPTH = 1 << AW;

  logic             sel;
  logic [AW-1:0]    base;
  logic [1:0]       cnt;
  logic             act, bwr, ilv;
  logic             p_vld, p_wr;
  logic [AW-1:0]    p_addr;
  logic [LANES-1:0] p_bw;
  logic [1:0]       nxt;

  function automatic logic [AW-1:0] step_addr(logic [AW-1:0] b, logic [1:0] k, logic il);
    return {b[AW-1:2], il ? (b[1:0] ^ k) : (b[1:0] + k)};
  endfunction

  assign sel = ~ce1_n & ~ce2_n & ce2;
  assign nxt = cnt + 2'd1;
  assign doe = p_vld & ~p_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      p_vld  <= 1'b0;
      p_wr   <= 1'b0;
      base   <= '0;
      cnt    <= '0;
      bwr    <= 1'b0;
      ilv    <= 1'b0;
      p_addr <= '0;
      p_bw   <= '1;
    end else if (!cken_n) begin
      p_bw <= bw_n;
      if (!adv) begin
        act    <= sel;
        p_vld  <= sel;
        p_wr   <= ~we_n;
        p_addr <= addr;
        if (sel) begin
          base <= addr;
          cnt  <= '0;
          bwr  <= ~we_n;
          ilv  <= seq_ilv;
        end
      end else begin
        p_vld  <= act;
        p_wr   <= bwr;
        p_addr <= step_addr(base, nxt, ilv);
        if (act) cnt <= nxt;
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk)
      if (!cken_n && p_vld && p_wr && !p_bw[i])
        mem[p_addr] <= din[i*LW +: LW];
    assign dout[i*LW +: LW] = doe ? mem[p_addr] : '0;
  end
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cken_n,
  input logic          ce1_n,
  input logic          ce2_n,
  input logic          ce2,
  input logic          we_n,
  input logic          adv,
  input logic          doe,
  input logic [DW-1:0] dout
);
  logic on;
  assign on = ~ce1_n & ~ce2_n & ce2;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !doe); // R10
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cken_n && doe) |=> (doe && $stable(dout))); // R1
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && !adv && !on) |=> !doe); // R3
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && !adv && on && we_n) |=> doe); // R4
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && !adv && on && !we_n) |=> !doe); // R4
endmodule

bind zbt_sram zbt_sram_chk #(.DW(LANES*LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
  .ce2(ce2), .we_n(we_n), .adv(adv), .doe(doe), .dout(dout)
);

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        cken_n = 0, ce1_n = 1, ce2_n = 0, ce2 = 1, we_n = 1, adv = 0, seq_ilv = 0;
  logic [3:0]  bw_n = '1;
  logic [5:0]  addr = '0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        doe;
  int n_chk = 0, n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  zbt_sram u_dut (.clk(clk), .rst_n(rst_n), .cken_n(cken_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .ce2(ce2), .we_n(we_n), .adv(adv), .bw_n(bw_n), .addr(addr), .seq_ilv(seq_ilv),
    .din(din), .dout(dout), .doe(doe));

  localparam logic [35:0] WA = 36'h1_2345_6789, D0 = 36'hA_0000_0001, D1 = 36'hB_0000_0002,
    D2 = 36'hC_0000_0003, D3 = 36'hD_0000_0004, F = 36'h1_1111_1111, G = 36'hE_EEEE_EEEE,
    H = 36'h5_5555_5555, X1 = 36'h7_7777_7777, X2 = 36'h3_3333_3333;

  function automatic logic [35:0] merge(logic [35:0] o, logic [35:0] w, logic [3:0] m);
    logic [35:0] r = o;
    for (int i = 0; i < 4; i++) if (!m[i]) r[i*9 +: 9] = w[i*9 +: 9];
    return r;
  endfunction

  task automatic chk(string req, logic [35:0] got, logic [35:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drv(logic cen, logic c1n, logic c2n, logic c2, logic w, logic ad,
                     logic [3:0] m, logic [5:0] a, logic sq, logic [35:0] d);
    cken_n = cen; ce1_n = c1n; ce2_n = c2n; ce2 = c2; we_n = w; adv = ad;
    bw_n = m; addr = a; seq_ilv = sq; din = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ld(logic w, logic [5:0] a, logic [3:0] m, logic sq, logic [35:0] d);
    drv(0, 0, 0, 1, w, 0, m, a, sq, d);
  endtask
  task automatic step(logic w, logic [35:0] d); drv(0, 0, 0, 1, w, 1, 4'h0, 6'd0, 0, d); endtask
  task automatic desel(logic [35:0] d); drv(0, 1, 0, 1, 1, 0, 4'h0, 6'd0, 0, d); endtask
  task automatic susp(logic [35:0] d); drv(1, 0, 0, 1, 0, 0, 4'h0, 6'd21, 1, d); endtask

  task automatic t_reset;
    chk("R10 doe after reset", {35'd0, doe}, 36'd0);
  endtask

  task automatic t_basic;
    ld(0, 6'd9, 4'h0, 1, '0);
    chk("R4 doe in write data cycle", {35'd0, doe}, 36'd0);
    ld(1, 6'd9, 4'h0, 1, WA);
    chk("R11 back-to-back read data", dout, WA);
    chk("R4 doe in read data cycle", {35'd0, doe}, 36'd1);
    desel('0);
    chk("R3 doe after deselect", {35'd0, doe}, 36'd0);
  endtask

  task automatic t_burst;
    ld(0, 6'd5, 4'h0, 1, '0);
    step(0, D0); step(1, D1); step(0, D2);
    ld(1, 6'd5, 4'h0, 0, D3);
    chk("R9 linear step0", dout, D0);
    step(0, '0); chk("R9 linear step1 addr6", dout, D3);
    step(0, '0); chk("R9 linear step2 addr7", dout, D2);
    step(0, '0); chk("R9 linear step3 addr4", dout, D1);
    step(0, '0); chk("R9 linear wrap addr5", dout, D0);
    ld(1, 6'd5, 4'h0, 1, '0);
    chk("R8 interleaved step0", dout, D0);
    step(0, '0); chk("R5 we_n ignored in read burst", {35'd0, doe}, 36'd1);
    chk("R8 interleaved step1 addr4", dout, D1);
    step(0, '0); chk("R8 interleaved step2 addr7", dout, D2);
    step(0, '0); chk("R8 interleaved step3 addr6", dout, D3);
    step(1, '0); chk("R8 interleaved wrap addr5", dout, D0);
    desel('0);
  endtask

  task automatic t_lanes;
    logic [35:0] exp = merge(F, G, 4'b0101);
    ld(0, 6'd12, 4'h0, 1, '0);
    ld(0, 6'd12, 4'b0101, 1, F);
    ld(0, 6'd12, 4'b1111, 1, G);
    ld(1, 6'd12, 4'h0, 1, H);
    chk("R7 lane mask 0101 then none", dout, exp);
    desel('0);
  endtask

  task automatic t_select;
    logic [35:0] exp = merge(F, G, 4'b0101);
    drv(0, 1, 0, 1, 1, 0, 4'h0, 6'd12, 1, '0);
    chk("R2 ce1_n high blocks read", {35'd0, doe}, 36'd0);
    drv(0, 0, 1, 1, 1, 0, 4'h0, 6'd12, 1, '0);
    chk("R2 ce2_n high blocks read", {35'd0, doe}, 36'd0);
    drv(0, 0, 0, 0, 1, 0, 4'h0, 6'd12, 1, '0);
    chk("R2 ce2 low blocks read", {35'd0, doe}, 36'd0);
    drv(0, 0, 0, 0, 0, 0, 4'h0, 6'd12, 1, '0);
    drv(0, 1, 0, 1, 0, 0, 4'h0, 6'd12, 1, X1);
    desel(X1);
    ld(1, 6'd12, 4'h0, 1, X1);
    chk("R2 deselected writes stored nothing", dout, exp);
    desel('0);
  endtask

  task automatic t_noop;
    desel('0);
    step(0, X1);
    chk("R6 advance after deselect stays quiet", {35'd0, doe}, 36'd0);
    step(0, X1);
    step(1, X1);
    ld(1, 6'd9, 4'h0, 1, X1);
    chk("R6 no-op wrote nothing", dout, WA);
    desel('0);
  endtask

  task automatic t_suspend;
    ld(1, 6'd5, 4'h0, 1, '0);
    susp('0);
    chk("R1 suspend holds doe", {35'd0, doe}, 36'd1);
    chk("R1 suspend holds dout", dout, D0);
    step(0, '0);
    chk("R1 counter held over suspend", dout, D1);
    desel('0);
    ld(0, 6'd20, 4'h0, 1, '0);
    susp(X1);
    ld(1, 6'd20, 4'h0, 1, X2);
    chk("R1 suspended edge did not write", dout, X2);
    desel('0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_burst;
    t_lanes;
    t_select;
    t_noop;
    t_suspend;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule